// File: doc/BRIEF.md
# Sub-Dword Operand Select Unit

This unit sits around a 32-bit integer ALU and handles operands and results that are narrower than a full word. For each of two source operands it picks a byte or half-word field, moves that field down to bit 0, and widens it back to 32 bits. The widening fills with zeros or copies the field's top bit, chosen per operand. For the destination it takes the low-order bits of the ALU result and places them into a selected byte, half-word or the whole word of the destination. The remaining destination bits are filled by a policy: all zeros, an upward sign copy with zeros below the field, or the previous destination contents.

The source selectors and the destination selector are independent 3-bit codes: 0 to 3 pick byte 0 to 3 (bits 7:0, 15:8, 23:16, 31:24), 4 picks the low half-word (15:0), 5 the high half-word (31:16) and 6 the whole word (31:0). Code 7 is handled as the whole word and raises an error flag. The fill policy is a 2-bit code: 0 zero pad, 1 sign copy upward, 2 keep old bits, and 3 acts as 2.

All selection logic is combinational. One register stage holds the results. A request presented with `in_valid` high appears on the outputs one clock later, together with `out_valid`. The registered outputs keep their values while `in_valid` is low.

Top module: `subdw_select_unit`

## Requirements
- R1: With sign extension off, a source output equals the selected field (codes 0-3 bytes, 4 low half, 5 high half, 6 word) moved to bit 0, with every bit above the field zero.
- R2: With sign extension on, every bit of a source output above the selected field equals the field's top bit (bit 7 of a byte, bit 15 of a half-word).
- R3: With code 6 selected, a source output equals the full source word whether sign extension is on or off.
- R4: The destination field selected by the destination code receives the low-order bits of the ALU result (8 for a byte, 16 for a half-word, 32 for the word).
- R5: Fill code 0 makes every destination bit outside the field zero.
- R6: Fill code 1 sets every destination bit above the field to bit 7 (byte) or bit 15 (half-word) of the ALU result, and every bit below the field to zero.
- R7: Fill codes 2 and 3 give every destination bit outside the field the value it has in the old destination input.
- R8: A selector code of 7 on any of the three selectors behaves as code 6, and `sel_err` is 1 in the output cycle; otherwise `sel_err` is 0.
- R9: Outputs for a request taken with `in_valid` high appear exactly one clock later with `out_valid` high; with `in_valid` low, `out_valid` falls and the data outputs and `sel_err` hold.
- R10: During reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present this cycle |
| src_a | input | 32 | First source operand |
| src_b | input | 32 | Second source operand |
| sel_a | input | 3 | Field code for first source |
| sel_b | input | 3 | Field code for second source |
| sext_a | input | 1 | Sign-extend first source field |
| sext_b | input | 1 | Sign-extend second source field |
| alu_res | input | 32 | ALU result to be placed |
| dst_old | input | 32 | Previous destination contents |
| dst_sel | input | 3 | Field code for destination |
| fill_mode | input | 2 | Policy for destination bits outside the field |
| opa_q | output | 32 | Widened first source |
| opb_q | output | 32 | Widened second source |
| dst_q | output | 32 | Merged destination word |
| out_valid | output | 1 | Outputs carry a new result |
| sel_err | output | 1 | A selector code of 7 was seen |

## Verification
The properties assume every input is driven to a known value on each rising edge after reset, and that data inputs matter only when `in_valid` is high; the bench therefore drives all inputs from reset onward and changes them only at the falling edge. Random requests draw every selector code including 7 and every fill code including 3, with operand and result patterns drawn so that the field top bit is set about half the time. Directed cases fix values whose field top bit is known, and idle cycles carry changed inputs so that the hold rule is seen at the outputs.

// File: rtl/subdw_select_unit.sv
module subdw_select_unit (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [31:0] src_a,
  input  logic [31:0] src_b,
  input  logic [2:0]  sel_a,
  input  logic [2:0]  sel_b,
  input  logic        sext_a,
  input  logic        sext_b,
  input  logic [31:0] alu_res,
  input  logic [31:0] dst_old,
  input  logic [2:0]  dst_sel,
  input  logic [1:0]  fill_mode,
  output logic [31:0] opa_q,
  output logic [31:0] opb_q,
  output logic [31:0] dst_q,
  output logic        out_valid,
  output logic        sel_err
);

  localparam logic [1:0] FILL_ZERO = 2'd0;
  localparam logic [1:0] FILL_SIGN = 2'd1;
  localparam logic [2:0] CODE_BAD  = 3'd7;

  function automatic logic [4:0] fld_lsb(input logic [2:0] s);
    case (s)
      3'd1:    fld_lsb = 5'd8;
      3'd2:    fld_lsb = 5'd16;
      3'd3:    fld_lsb = 5'd24;
      3'd5:    fld_lsb = 5'd16;
      default: fld_lsb = 5'd0;
    endcase
  endfunction

  function automatic logic [31:0] fld_mask(input logic [2:0] s);
    case (s)
      3'd0, 3'd1, 3'd2, 3'd3: fld_mask = 32'h0000_00FF;
      3'd4, 3'd5:             fld_mask = 32'h0000_FFFF;
      default:                fld_mask = 32'hFFFF_FFFF;
    endcase
  endfunction

  function automatic logic [4:0] fld_msb(input logic [2:0] s);
    case (s)
      3'd0, 3'd1, 3'd2, 3'd3: fld_msb = 5'd7;
      3'd4, 3'd5:             fld_msb = 5'd15;
      default:                fld_msb = 5'd31;
    endcase
  endfunction

  function automatic logic [31:0] widen(input logic [31:0] src, input logic [2:0] s,
                                        input logic sx);
    logic [31:0] raw;
    raw = (src >> fld_lsb(s)) & fld_mask(s);
    widen = (sx && raw[fld_msb(s)]) ? (raw | ~fld_mask(s)) : raw;
  endfunction

  logic [31:0] opa_d, opb_d, dst_d;
  logic [31:0] put_mask, low_mask, high_mask, placed;
  logic        res_top, err_d;

  assign opa_d = widen(src_a, sel_a, sext_a);
  assign opb_d = widen(src_b, sel_b, sext_b);

  assign put_mask  = fld_mask(dst_sel) << fld_lsb(dst_sel);
  assign low_mask  = ~(32'hFFFF_FFFF << fld_lsb(dst_sel));
  assign high_mask = ~(put_mask | low_mask);
  assign placed    = (alu_res & fld_mask(dst_sel)) << fld_lsb(dst_sel);
  assign res_top   = alu_res[fld_msb(dst_sel)];

  always_comb begin
    case (fill_mode)
      FILL_ZERO: dst_d = placed;
      FILL_SIGN: dst_d = placed | (res_top ? high_mask : 32'h0);
      default:   dst_d = placed | (dst_old & ~put_mask);
    endcase
  end

  assign err_d = (sel_a == CODE_BAD) || (sel_b == CODE_BAD) || (dst_sel == CODE_BAD);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      opa_q     <= '0;
      opb_q     <= '0;
      dst_q     <= '0;
      sel_err   <= 1'b0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        opa_q   <= opa_d;
        opb_q   <= opb_d;
        dst_q   <= dst_d;
        sel_err <= err_d;
      end
    end
  end

endmodule

module subdw_select_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic [31:0] src_a,
  input logic [31:0] src_b,
  input logic [2:0]  sel_a,
  input logic [2:0]  sel_b,
  input logic        sext_a,
  input logic        sext_b,
  input logic [31:0] alu_res,
  input logic [31:0] dst_old,
  input logic [2:0]  dst_sel,
  input logic [1:0]  fill_mode,
  input logic [31:0] opa_q,
  input logic [31:0] opb_q,
  input logic [31:0] dst_q,
  input logic        out_valid,
  input logic        sel_err
);

  assert_valid_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  assert_idle_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(opa_q) && $stable(opb_q) && $stable(dst_q) && $stable(sel_err)));

  assert_bad_code_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (sel_a == 3'd7 || sel_b == 3'd7 || dst_sel == 3'd7)) |=> sel_err);

  assert_good_code_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && sel_a != 3'd7 && sel_b != 3'd7 && dst_sel != 3'd7) |=> !sel_err);

  assert_word_pass_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && sel_b == 3'd6) |=> (opb_q == $past(src_b)));

  assert_byte_zero_ext_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && sel_a == 3'd0 && !sext_a) |=> (opa_q[31:8] == 24'h0));

  assert_half_place_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && dst_sel == 3'd5) |=> (dst_q[31:16] == $past(alu_res[15:0])));

  assert_pad_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && fill_mode == 2'd0 && dst_sel == 3'd0) |=> (dst_q[31:8] == 24'h0));

  assert_keep_old_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && fill_mode[1] && dst_sel == 3'd3) |=> (dst_q[23:0] == $past(dst_old[23:0])));

endmodule

bind subdw_select_unit subdw_select_chk u_chk (.*);

// File: tb/sim_subdw_select_unit.sv
`timescale 1ns/1ps
module sim_subdw_select_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] src_a = '0, src_b = '0, alu_res = '0, dst_old = '0;
  logic [2:0]  sel_a = '0, sel_b = '0, dst_sel = '0;
  logic        sext_a = 1'b0, sext_b = 1'b0;
  logic [1:0]  fill_mode = '0;
  logic [31:0] opa_q, opb_q, dst_q;
  logic        out_valid, sel_err;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  subdw_select_unit u0 (.*);

  function automatic int f_lo(input logic [2:0] s);
    case (s)
      3'd0: return 0;  3'd1: return 8;  3'd2: return 16; 3'd3: return 24;
      3'd4: return 0;  3'd5: return 16; default: return 0;
    endcase
  endfunction

  function automatic int f_w(input logic [2:0] s);
    if (s < 3'd4) return 8;
    if (s < 3'd6) return 16;
    return 32;
  endfunction

  function automatic logic [31:0] exp_src(input logic [31:0] v, input logic [2:0] s,
                                          input logic sx);
    logic [31:0] r;
    int lo, w;
    lo = f_lo(s);
    w  = f_w(s);
    for (int i = 0; i < 32; i++) begin
      if (i < w) r[i] = v[lo + i];
      else       r[i] = sx ? v[lo + w - 1] : 1'b0;
    end
    return r;
  endfunction

  function automatic logic [31:0] exp_dst(input logic [31:0] res, input logic [31:0] old,
                                          input logic [2:0] s, input logic [1:0] m);
    logic [31:0] r;
    int lo, w;
    lo = f_lo(s);
    w  = f_w(s);
    for (int i = 0; i < 32; i++) begin
      if (i >= lo && i < lo + w) r[i] = res[i - lo];
      else if (m == 2'd0)        r[i] = 1'b0;
      else if (m == 2'd1)        r[i] = (i >= lo + w) ? res[w - 1] : 1'b0;
      else                       r[i] = old[i];
    end
    return r;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  logic [31:0] e_a, e_b, e_d;
  logic        e_err;

  task automatic apply(input string req, input logic [31:0] a, input logic [2:0] sa, input logic xa,
                       input logic [31:0] b, input logic [2:0] sb, input logic xb,
                       input logic [31:0] res, input logic [31:0] old,
                       input logic [2:0] ds, input logic [1:0] fm);
    src_a = a; sel_a = sa; sext_a = xa;
    src_b = b; sel_b = sb; sext_b = xb;
    alu_res = res; dst_old = old; dst_sel = ds; fill_mode = fm;
    in_valid = 1'b1;
    e_a = exp_src(a, (sa == 3'd7) ? 3'd6 : sa, xa);
    e_b = exp_src(b, (sb == 3'd7) ? 3'd6 : sb, xb);
    e_d = exp_dst(res, old, (ds == 3'd7) ? 3'd6 : ds, fm);
    e_err = (sa == 3'd7) || (sb == 3'd7) || (ds == 3'd7);
    @(negedge clk);
    chk({req, " opa"}, opa_q, e_a);
    chk({req, " opb"}, opb_q, e_b);
    chk({req, " dst"}, dst_q, e_d);
    chk({req, " err R8"}, {31'b0, sel_err}, {31'b0, e_err});
    chk("R9 valid", {31'b0, out_valid}, 32'd1);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = $urandom(32'h5EED_0A17);
    repeat (3) @(negedge clk);
    chk("R10 opa reset", opa_q, 32'h0);
    chk("R10 dst reset", dst_q, 32'h0);
    chk("R10 valid reset", {30'b0, out_valid, sel_err}, 32'h0);
    rst_n = 1'b1;

    for (int s = 0; s < 7; s++) begin
      apply("R1", 32'h8091_A27F, 3'(s), 1'b0, 32'h7F80_01FE, 3'(s), 1'b1,
            32'h0, 32'h0, 3'd6, 2'd2);
    end
    apply("R2", 32'h0000_0080, 3'd0, 1'b1, 32'h8000_0000, 3'd5, 1'b1,
          32'h0, 32'h0, 3'd6, 2'd0);
    chk("R2 byte sign", opa_q, 32'hFFFF_FF80);
    chk("R2 half sign", opb_q, 32'hFFFF_8000);
    apply("R3", 32'h8000_0001, 3'd6, 1'b1, 32'hF0F0_0F0F, 3'd6, 1'b0,
          32'h0, 32'h0, 3'd6, 2'd0);
    chk("R3 word passes", opa_q, 32'h8000_0001);

    apply("R4", 32'h0, 3'd6, 1'b0, 32'h0, 3'd6, 1'b0, 32'hDEAD_BEEF, 32'h1234_5678, 3'd6, 2'd0);
    chk("R4 word result", dst_q, 32'hDEAD_BEEF);
    apply("R5", 32'h0, 3'd6, 1'b0, 32'h0, 3'd6, 1'b0, 32'h0000_00F1, 32'h1234_5678, 3'd1, 2'd0);
    chk("R5 pad byte1", dst_q, 32'h0000_F100);
    apply("R6", 32'h0, 3'd6, 1'b0, 32'h0, 3'd6, 1'b0, 32'h0000_00F1, 32'h1234_5678, 3'd1, 2'd1);
    chk("R6 sign byte1", dst_q, 32'hFFFF_F100);
    apply("R6", 32'h0, 3'd6, 1'b0, 32'h0, 3'd6, 1'b0, 32'hFFFF_7001, 32'h1234_5678, 3'd4, 2'd1);
    chk("R6 positive half", dst_q, 32'h0000_7001);
    apply("R7", 32'h0, 3'd6, 1'b0, 32'h0, 3'd6, 1'b0, 32'h0000_00F1, 32'h1234_5678, 3'd1, 2'd2);
    chk("R7 keep byte1", dst_q, 32'h1234_F178);
    apply("R7", 32'h0, 3'd6, 1'b0, 32'h0, 3'd6, 1'b0, 32'h0000_ABCD, 32'h1234_5678, 3'd5, 2'd3);
    chk("R7 code3 keep", dst_q, 32'hABCD_5678);
    apply("R8", 32'h8765_4321, 3'd7, 1'b1, 32'h0, 3'd0, 1'b0, 32'h0, 32'h0, 3'd0, 2'd0);
    chk("R8 code7 word", opa_q, 32'h8765_4321);
    apply("R8", 32'h0, 3'd0, 1'b0, 32'h0, 3'd0, 1'b0, 32'h1357_9BDF, 32'hFFFF_FFFF, 3'd7, 2'd0);
    chk("R8 dst code7", dst_q, 32'h1357_9BDF);

    for (int n = 0; n < 600; n++) begin
      logic [31:0] ra, rb, rr, ro;
      ra = $urandom; rb = $urandom; rr = $urandom; ro = $urandom;
      apply("R1-random", ra, 3'($urandom % 8), 1'($urandom), rb, 3'($urandom % 8), 1'($urandom),
            rr, ro, 3'($urandom % 8), 2'($urandom % 4));
      if (n % 50 == 49) begin
        in_valid = 1'b0;
        src_a = ~src_a; src_b = ~src_b; alu_res = ~alu_res; dst_old = ~dst_old;
        sel_a = 3'd7; dst_sel = 3'd7;
        @(negedge clk);
        chk("R9 hold opa", opa_q, e_a);
        chk("R9 hold opb", opb_q, e_b);
        chk("R9 hold dst", dst_q, e_d);
        chk("R9 hold err", {31'b0, sel_err}, {31'b0, e_err});
        chk("R9 valid low", {31'b0, out_valid}, 32'd0);
      end
    end

    in_valid = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    chk("R10 reset again", {opa_q[0], opb_q[0], out_valid, sel_err} == 4'b0 && dst_q == 32'h0 ? 32'd1 : 32'd0, 32'd1);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule